// File: doc/BRIEF.md
# Miss and Write Buffer Allocator

This block keeps the entry bookkeeping for the two small outstanding-request queues of a cache. Queue 0 holds read misses, both cacheable and uncacheable. Queue 1 is the write buffer. A single command port takes one command per cycle. Three of the commands allocate an entry; the other two mark an entry as in service or free its slot. On allocation the block picks the queue and computes the address and size the entry holds. It also stamps the entry with a running order number.

The queue index serves as the cause code on two paths: the path that stalls the request side and the path that asks for the memory-side bus. An allocation that leaves a queue with every slot active raises a one-cycle block-set pulse and sets that queue's bit in the block mask. Marking an entry in service removes it from the active count. The clear pulse fires only when that service moves the queue from full to not full.

A two-state machine follows the block mask. The states are ST_OPEN (mask zero) and ST_BLOCKED (any mask bit set). The OPEN→BLOCKED transition ("block") happens when a set pulse makes the mask non-zero. The BLOCKED→OPEN transition ("release") happens when a clear pulse empties the mask. A combinational peek port reads any entry back.

Top module: `miss_wbuf_alloc`

## Requirements
- R1: After reset, every entry is invalid, the block mask is 0, `blocked` is 0, `q_full` is 0, all pulse outputs are 0 and the order counter is 0.
- R2: Op code 0 (cacheable read miss) allocates in queue 0. The entry stores the address with its low log2(BLK_BYTES) bits cleared and the size BLK_BYTES (64 by default). Command responses appear in the cycle after the command edge.
- R3: Op code 1 (uncacheable read) allocates in queue 0 and stores the exact address and size.
- R4: Op code 2 (write) allocates in queue 1 (the write buffer) and stores the exact address and size.
- R5: Each successful allocation stores the current 16-bit order counter and reports it on `rsp_order`; the counter then increments by one and wraps on overflow. A rejected command does not advance it.
- R6: An allocation takes the lowest-numbered invalid slot of its queue. If the queue has no invalid slot, the command answers `rsp_err` and changes no state. `rsp_ok` and `rsp_err` are never both high.
- R7: When an allocation leaves every slot of its queue active (valid and not in service), `blk_set` pulses with `blk_cause` equal to the queue index (0 miss, 1 write) and that mask bit is set.
- R8: When `cmd_bus` is high on a successful allocation, `bus_req` pulses with `bus_cause` equal to the queue index; otherwise `bus_req` stays low.
- R9: Op code 3 (service) marks a valid, not-in-service entry as in service and drops it from the active count. `blk_clr` pulses with that cause, and the mask bit clears, only if the queue was full before the command and is not full after it.
- R10: Op code 4 (free) invalidates an entry that is in service. Serving an invalid or already-served entry, or freeing an entry that is invalid or not in service, answers `rsp_err` and changes nothing.
- R11: `blocked` is 1 exactly when the block mask is non-zero. It is the ST_BLOCKED state of the machine.
- R12: Op codes 5 to 7 are reserved and answer `rsp_err` with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 miss, 1 uncacheable, 2 write, 3 service, 4 free |
| cmd_queue | input | 1 | Target queue for service and free |
| cmd_slot | input | SLOT_W | Target slot for service and free |
| cmd_addr | input | ADDR_W | Request address |
| cmd_size | input | SIZE_W | Request size in bytes |
| cmd_bus | input | 1 | Ask for the memory-side bus on allocation |
| rsp_ok | output | 1 | Command accepted |
| rsp_err | output | 1 | Command rejected |
| rsp_queue | output | 1 | Queue the command addressed |
| rsp_slot | output | SLOT_W | Slot allocated or addressed |
| rsp_order | output | ORD_W | Order number given to the allocation |
| blk_set | output | 1 | Block-set pulse |
| blk_clr | output | 1 | Block-clear pulse |
| blk_cause | output | 1 | Cause code for set or clear |
| bus_req | output | 1 | Memory-side bus request pulse |
| bus_cause | output | 1 | Cause code for the bus request |
| blk_mask | output | 2 | Per-cause block bits |
| blocked | output | 1 | Any cause blocking |
| q_full | output | 2 | Per-queue full (all slots active) |
| peek_queue | input | 1 | Queue to read |
| peek_slot | input | SLOT_W | Slot to read |
| peek_valid | output | 1 | Entry valid |
| peek_insvc | output | 1 | Entry in service |
| peek_addr | output | ADDR_W | Stored address |
| peek_size | output | SIZE_W | Stored size |
| peek_order | output | ORD_W | Stored order number |

## Verification
The bench fills the miss queue until the block-set pulse fires, and checks that the pulse comes on the last allocation only, so a design that raised it one entry early would fail. It serves an entry in a full queue and then another in a no-longer-full one. A design that cleared on every service would pulse twice; a design that never cleared would leave `blocked` stuck. It also builds a queue whose slots are all valid while one is in service, so it is not full but cannot accept an allocation. That must be rejected without a set pulse. A rejected allocation is followed by a good one to show the order number was not consumed. With both causes set, clearing one must leave `blocked` high. A design that used one bit for both causes would drop it.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
    typedef enum logic [2:0] {
        OP_ALLOC_MISS = 3'd0,
        OP_ALLOC_UNC  = 3'd1,
        OP_ALLOC_WR   = 3'd2,
        OP_SERVICE    = 3'd3,
        OP_FREE       = 3'd4
    } op_e;

    localparam logic Q_MISS = 1'b0;
    localparam logic Q_WBUF = 1'b1;

    typedef enum logic {
        ST_OPEN    = 1'b0,
        ST_BLOCKED = 1'b1
    } blk_state_e;
endpackage

// File: rtl/mwa_queue.sv
module mwa_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int ORD_W  = 16,
    parameter int SLOT_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic [ORD_W-1:0]  alloc_order,
    input  logic              svc_en,
    input  logic              free_en,
    input  logic [SLOT_W-1:0] op_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              has_free,
    output logic [SLOT_W-1:0] free_slot,
    output logic [CNT_W-1:0]  active_cnt,
    output logic              op_valid,
    output logic              op_insvc,
    output logic              rd_valid,
    output logic              rd_insvc,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SIZE_W-1:0] rd_size,
    output logic [ORD_W-1:0]  rd_order
);
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  svc_q;
    logic [ADDR_W-1:0] addr_q  [DEPTH];
    logic [SIZE_W-1:0] size_q  [DEPTH];
    logic [ORD_W-1:0]  order_q [DEPTH];

    logic op_in_range, rd_in_range;
    assign op_in_range = int'(op_slot) < DEPTH;
    assign rd_in_range = int'(rd_slot) < DEPTH;

    // lowest free slot and active count
    always_comb begin
        has_free   = 1'b0;
        free_slot  = '0;
        active_cnt = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                has_free  = 1'b1;
                free_slot = SLOT_W'(i);
            end
            if (vld_q[i] && !svc_q[i]) begin
                active_cnt = active_cnt + 1'b1;
            end
        end
    end

    assign op_valid = op_in_range && vld_q[op_slot];
    assign op_insvc = op_in_range && svc_q[op_slot];
    assign rd_valid = rd_in_range && vld_q[rd_slot];
    assign rd_insvc = rd_in_range && svc_q[rd_slot];
    assign rd_addr  = rd_in_range ? addr_q[rd_slot]  : '0;
    assign rd_size  = rd_in_range ? size_q[rd_slot]  : '0;
    assign rd_order = rd_in_range ? order_q[rd_slot] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            svc_q <= '0;
        end else begin
            if (alloc_en) begin
                vld_q[free_slot] <= 1'b1;
                svc_q[free_slot] <= 1'b0;
            end
            if (svc_en && op_in_range) begin
                svc_q[op_slot] <= 1'b1;
            end
            if (free_en && op_in_range) begin
                vld_q[op_slot] <= 1'b0;
                svc_q[op_slot] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            addr_q[free_slot]  <= alloc_addr;
            size_q[free_slot]  <= alloc_size;
            order_q[free_slot] <= alloc_order;
        end
    end
endmodule

// File: rtl/miss_wbuf_alloc.sv
module miss_wbuf_alloc #(
    parameter int MISS_DEPTH = 4,
    parameter int WB_DEPTH   = 4,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 8,
    parameter int ORD_W      = 16,
    parameter int BLK_BYTES  = 64,
    localparam int MAX_DEPTH = (MISS_DEPTH > WB_DEPTH) ? MISS_DEPTH : WB_DEPTH,
    localparam int SLOT_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_queue,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_bus,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic              rsp_queue,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [ORD_W-1:0]  rsp_order,
    output logic              blk_set,
    output logic              blk_clr,
    output logic              blk_cause,
    output logic              bus_req,
    output logic              bus_cause,
    output logic [1:0]        blk_mask,
    output logic              blocked,
    output logic [1:0]        q_full,
    input  logic              peek_queue,
    input  logic [SLOT_W-1:0] peek_slot,
    output logic              peek_valid,
    output logic              peek_insvc,
    output logic [ADDR_W-1:0] peek_addr,
    output logic [SIZE_W-1:0] peek_size,
    output logic [ORD_W-1:0]  peek_order
);
    import mwa_pkg::*;

    localparam int CNT_W = $clog2(MAX_DEPTH + 1);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam logic [SIZE_W-1:0] BLK_SIZE = SIZE_W'(BLK_BYTES);

    // per-queue views
    logic              q_has_free [2];
    logic [SLOT_W-1:0] q_free_slot[2];
    logic [CNT_W-1:0]  q_active   [2];
    logic              q_op_valid [2];
    logic              q_op_insvc [2];
    logic              q_rd_valid [2];
    logic              q_rd_insvc [2];
    logic [ADDR_W-1:0] q_rd_addr  [2];
    logic [SIZE_W-1:0] q_rd_size  [2];
    logic [ORD_W-1:0]  q_rd_order [2];

    // command decode
    logic              tgt;
    logic              is_alloc, is_svc, is_free;
    logic [ADDR_W-1:0] st_addr;
    logic [SIZE_W-1:0] st_size;
    logic              alloc_go, svc_go, free_go, cmd_ok, cmd_err;
    logic [CNT_W-1:0]  tgt_depth, cnt_after;
    logic              full_before, full_after, set_now, clr_now;
    logic [1:0]        mask_q, mask_nxt;
    logic [ORD_W-1:0]  order_q;
    blk_state_e        state_q, state_nxt;

    always_comb begin
        tgt      = cmd_queue;
        is_alloc = 1'b0;
        is_svc   = 1'b0;
        is_free  = 1'b0;
        st_addr  = cmd_addr;
        st_size  = cmd_size;
        unique case (cmd_op)
            OP_ALLOC_MISS: begin
                is_alloc = 1'b1;
                tgt      = Q_MISS;
                st_addr  = {cmd_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                st_size  = BLK_SIZE;
            end
            OP_ALLOC_UNC: begin
                is_alloc = 1'b1;
                tgt      = Q_MISS;
            end
            OP_ALLOC_WR: begin
                is_alloc = 1'b1;
                tgt      = Q_WBUF;
            end
            OP_SERVICE: is_svc  = 1'b1;
            OP_FREE:    is_free = 1'b1;
            default: ;
        endcase
    end

    assign alloc_go = cmd_valid && is_alloc && q_has_free[tgt];
    assign svc_go   = cmd_valid && is_svc  && q_op_valid[tgt] && !q_op_insvc[tgt];
    assign free_go  = cmd_valid && is_free && q_op_valid[tgt] &&  q_op_insvc[tgt];
    assign cmd_ok   = alloc_go || svc_go || free_go;
    assign cmd_err  = cmd_valid && !cmd_ok;

    // full tracking around the command
    always_comb begin
        tgt_depth = tgt ? CNT_W'(WB_DEPTH) : CNT_W'(MISS_DEPTH);
        cnt_after = q_active[tgt];
        if (alloc_go) cnt_after = q_active[tgt] + 1'b1;
        if (svc_go)   cnt_after = q_active[tgt] - 1'b1;
        full_before = (q_active[tgt] == tgt_depth);
        full_after  = (cnt_after == tgt_depth);
        set_now     = alloc_go && full_after;
        clr_now     = svc_go && full_before && !full_after;
        mask_nxt    = mask_q;
        if (set_now) mask_nxt[tgt] = 1'b1;
        if (clr_now) mask_nxt[tgt] = 1'b0;
    end

    // two queues, one per cause
    for (genvar g = 0; g < 2; g++) begin : g_q
        localparam int QD = (g == 0) ? MISS_DEPTH : WB_DEPTH;
        logic sel;
        assign sel = (tgt == 1'(g));
        mwa_queue #(
            .DEPTH(QD), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ORD_W(ORD_W),
            .SLOT_W(SLOT_W), .CNT_W(CNT_W)
        ) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_go && sel),
            .alloc_addr (st_addr),
            .alloc_size (st_size),
            .alloc_order(order_q),
            .svc_en     (svc_go && sel),
            .free_en    (free_go && sel),
            .op_slot    (cmd_slot),
            .rd_slot    (peek_slot),
            .has_free   (q_has_free[g]),
            .free_slot  (q_free_slot[g]),
            .active_cnt (q_active[g]),
            .op_valid   (q_op_valid[g]),
            .op_insvc   (q_op_insvc[g]),
            .rd_valid   (q_rd_valid[g]),
            .rd_insvc   (q_rd_insvc[g]),
            .rd_addr    (q_rd_addr[g]),
            .rd_size    (q_rd_size[g]),
            .rd_order   (q_rd_order[g])
        );
        assign q_full[g] = (q_active[g] == CNT_W'(QD));
    end

    // block state machine: next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OPEN:    if (mask_nxt != 2'b00) state_nxt = ST_BLOCKED;
            ST_BLOCKED: if (mask_nxt == 2'b00) state_nxt = ST_OPEN;
            default:    state_nxt = ST_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            mask_q  <= 2'b00;
            order_q <= '0;
        end else begin
            state_q <= state_nxt;
            mask_q  <= mask_nxt;
            if (alloc_go) order_q <= order_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_queue <= 1'b0;
            rsp_slot  <= '0;
            rsp_order <= '0;
            blk_set   <= 1'b0;
            blk_clr   <= 1'b0;
            blk_cause <= 1'b0;
            bus_req   <= 1'b0;
            bus_cause <= 1'b0;
        end else begin
            rsp_ok    <= cmd_ok;
            rsp_err   <= cmd_err;
            rsp_queue <= tgt;
            rsp_slot  <= alloc_go ? q_free_slot[tgt] : cmd_slot;
            rsp_order <= alloc_go ? order_q : '0;
            blk_set   <= set_now;
            blk_clr   <= clr_now;
            blk_cause <= tgt;
            bus_req   <= alloc_go && cmd_bus;
            bus_cause <= tgt;
        end
    end

    assign blk_mask   = mask_q;
    assign blocked    = (state_q == ST_BLOCKED);
    assign peek_valid = q_rd_valid[peek_queue];
    assign peek_insvc = q_rd_insvc[peek_queue];
    assign peek_addr  = q_rd_addr[peek_queue];
    assign peek_size  = q_rd_size[peek_queue];
    assign peek_order = q_rd_order[peek_queue];
endmodule

// File: rtl/mwa_checker.sv
module mwa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rsp_ok,
    input logic       rsp_err,
    input logic       blk_set,
    input logic       blk_clr,
    input logic       blk_cause,
    input logic       bus_req,
    input logic [1:0] blk_mask,
    input logic       blocked,
    input logic [1:0] q_full
);
    assert_set_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_set |-> (q_full[blk_cause] && blk_mask[blk_cause]));

    assert_clr_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clr |-> (!q_full[blk_cause] && $past(q_full[blk_cause]) && !blk_mask[blk_cause]));

    assert_set_clr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_set && blk_clr));

    assert_ok_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_err));

    assert_bus_needs_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> rsp_ok);

    assert_blocked_tracks_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        blocked == (blk_mask != 2'b00));

    assert_err_keeps_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(blk_mask));
endmodule

bind miss_wbuf_alloc mwa_checker u_mwa_checker (.*);

// File: tb/tb_miss_wbuf_alloc.sv
module tb_miss_wbuf_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_queue = 1'b0;
    logic [1:0]  cmd_slot = '0;
    logic [31:0] cmd_addr = '0;
    logic [7:0]  cmd_size = '0;
    logic        cmd_bus = 1'b0;
    logic        rsp_ok, rsp_err, rsp_queue;
    logic [1:0]  rsp_slot;
    logic [15:0] rsp_order;
    logic        blk_set, blk_clr, blk_cause, bus_req, bus_cause;
    logic [1:0]  blk_mask, q_full;
    logic        blocked;
    logic        peek_queue = 1'b0;
    logic [1:0]  peek_slot = '0;
    logic        peek_valid, peek_insvc;
    logic [31:0] peek_addr;
    logic [7:0]  peek_size;
    logic [15:0] peek_order;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    miss_wbuf_alloc dut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic q, input logic [1:0] slot,
                         input logic [31:0] addr, input logic [7:0] size, input logic bus);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_queue = q; cmd_slot = slot;
        cmd_addr = addr; cmd_size = size; cmd_bus = bus;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic peek(input logic q, input logic [1:0] slot);
        peek_queue = q; peek_slot = slot;
        #1;
    endtask

    task automatic expect_alloc(input string req, input logic q, input logic [1:0] slot,
                                input logic [15:0] ord, input logic bset, input logic breq);
        chk(req, "rsp_ok", rsp_ok, 1);
        chk(req, "rsp_queue", rsp_queue, q);
        chk(req, "rsp_slot", rsp_slot, slot);
        chk(req, "rsp_order", rsp_order, ord);
        chk(req, "blk_set", blk_set, bset);
        chk(req, "bus_req", bus_req, breq);
    endtask

    task automatic t_reset;
        chk("R1", "rsp_ok", rsp_ok, 0);
        chk("R1", "blk_set", blk_set, 0);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "blk_mask", blk_mask, 0);
        chk("R1", "blocked", blocked, 0);
        chk("R1", "q_full", q_full, 0);
        peek(0, 0); chk("R1", "miss valid", peek_valid, 0);
        peek(1, 3); chk("R1", "wbuf valid", peek_valid, 0);
    endtask

    task automatic t_kinds;
        issue(3'd0, 0, 0, 32'h1234_5678, 8'd4, 0);       // R2 cacheable miss
        expect_alloc("R2", 0, 0, 16'd0, 0, 0);
        peek(0, 0);
        chk("R2", "aligned addr", peek_addr, 32'h1234_5640);
        chk("R2", "block size", peek_size, 8'd64);
        chk("R5", "stored order", peek_order, 16'd0);
        issue(3'd1, 0, 0, 32'h1000_0003, 8'd2, 1);       // R3 uncacheable
        expect_alloc("R3", 0, 1, 16'd1, 0, 1);
        chk("R8", "bus_cause miss", bus_cause, 0);
        peek(0, 1);
        chk("R3", "exact addr", peek_addr, 32'h1000_0003);
        chk("R3", "exact size", peek_size, 8'd2);
        issue(3'd2, 0, 0, 32'h2000_0005, 8'd3, 1);       // R4 write
        expect_alloc("R4", 1, 0, 16'd2, 0, 1);
        chk("R8", "bus_cause wbuf", bus_cause, 1);
        peek(1, 0);
        chk("R4", "exact addr", peek_addr, 32'h2000_0005);
        chk("R4", "exact size", peek_size, 8'd3);
        chk("R4", "miss q untouched", q_full, 2'b00);
    endtask

    task automatic t_fill_miss;
        issue(3'd0, 0, 0, 32'h0000_0047, 8'd1, 0);
        expect_alloc("R7", 0, 2, 16'd3, 0, 0);           // not yet full
        chk("R11", "still open", blocked, 0);
        issue(3'd0, 0, 0, 32'h0000_0080, 8'd1, 0);
        expect_alloc("R7", 0, 3, 16'd4, 1, 0);
        chk("R7", "blk_cause", blk_cause, 0);
        chk("R7", "blk_mask", blk_mask, 2'b01);
        chk("R11", "blocked", blocked, 1);
        chk("R7", "q_full", q_full, 2'b01);
        issue(3'd1, 0, 0, 32'h0000_1111, 8'd4, 1);       // R6 rejected
        chk("R6", "rsp_err", rsp_err, 1);
        chk("R6", "rsp_ok", rsp_ok, 0);
        chk("R8", "no bus_req", bus_req, 0);
        chk("R6", "no blk_set", blk_set, 0);
    endtask

    task automatic t_service;
        issue(3'd3, 0, 2'd1, 0, 0, 0);                   // R9 full -> not full
        chk("R9", "rsp_ok", rsp_ok, 1);
        chk("R9", "blk_clr", blk_clr, 1);
        chk("R9", "blk_cause", blk_cause, 0);
        chk("R11", "released", blocked, 0);
        chk("R9", "q_full", q_full, 2'b00);
        peek(0, 1); chk("R9", "insvc", peek_insvc, 1);
        issue(3'd3, 0, 2'd2, 0, 0, 0);                   // not full before
        chk("R9", "rsp_ok second", rsp_ok, 1);
        chk("R9", "no second clr", blk_clr, 0);
        issue(3'd3, 0, 2'd1, 0, 0, 0);                   // R10 double service
        chk("R10", "double svc err", rsp_err, 1);
        issue(3'd4, 0, 2'd0, 0, 0, 0);                   // R10 free active
        chk("R10", "free active err", rsp_err, 1);
        peek(0, 0); chk("R10", "entry kept", peek_valid, 1);
        issue(3'd4, 0, 2'd1, 0, 0, 0);
        chk("R10", "free ok", rsp_ok, 1);
        peek(0, 1); chk("R10", "freed", peek_valid, 0);
        issue(3'd0, 0, 0, 32'h0000_9999, 8'd8, 0);       // R5 rejected did not consume
        expect_alloc("R5", 0, 1, 16'd5, 0, 0);
        peek(0, 1); chk("R2", "aligned 9999", peek_addr, 32'h0000_9980);
        issue(3'd0, 0, 0, 32'h0000_0100, 8'd8, 0);       // R6 no slot, not full
        chk("R6", "no slot err", rsp_err, 1);
        chk("R6", "no blk_set", blk_set, 0);
        chk("R6", "not full", q_full, 2'b00);
    endtask

    task automatic t_two_causes;
        issue(3'd2, 0, 0, 32'h3000_0001, 8'd1, 0);
        expect_alloc("R4", 1, 1, 16'd6, 0, 0);
        issue(3'd2, 0, 0, 32'h3000_0002, 8'd1, 0);
        expect_alloc("R4", 1, 2, 16'd7, 0, 0);
        issue(3'd2, 0, 0, 32'h3000_0003, 8'd1, 1);
        expect_alloc("R7", 1, 3, 16'd8, 1, 1);
        chk("R7", "wbuf cause", blk_cause, 1);
        chk("R7", "mask wbuf", blk_mask, 2'b10);
        issue(3'd4, 0, 2'd2, 0, 0, 0);
        chk("R10", "free served", rsp_ok, 1);
        issue(3'd0, 0, 0, 32'h0000_01FF, 8'd1, 0);
        expect_alloc("R7", 0, 2, 16'd9, 1, 0);
        chk("R2", "blk_cause miss", blk_cause, 0);
        chk("R7", "mask both", blk_mask, 2'b11);
        peek(0, 2); chk("R2", "aligned 1ff", peek_addr, 32'h0000_01C0);
        issue(3'd3, 1, 2'd0, 0, 0, 0);
        chk("R9", "clr wbuf", blk_clr, 1);
        chk("R9", "clr cause", blk_cause, 1);
        chk("R9", "mask left", blk_mask, 2'b01);
        chk("R11", "still blocked", blocked, 1);
    endtask

    task automatic t_reserved;
        issue(3'd6, 0, 0, 32'h0, 8'd0, 1);
        chk("R12", "rsp_err", rsp_err, 1);
        chk("R12", "bus_req", bus_req, 0);
        chk("R12", "mask kept", blk_mask, 2'b01);
        issue(3'd5, 1, 2'd1, 32'h0, 8'd0, 0);
        chk("R12", "rsp_err 5", rsp_err, 1);
        peek(1, 1); chk("R12", "entry kept", peek_valid, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_kinds();
        t_fill_miss();
        t_service();
        t_two_causes();
        t_reserved();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule